// File: doc/BRIEF.md
# I2C Slave Engine with Maskable 7/10-bit Address

This block is the target side of a two-wire serial bus. It watches the clock and data lines through synchronised pin inputs. It pulls either line low through an enable output, so the pad is open-drain. It answers to one own address, in either 7-bit or 10-bit form. A per-bit mask turns chosen address bits into don't-care positions.

Once addressed for writing, the block collects each byte in a private shift register. It then moves the byte into a holding register that the host reads. When the master reads, the block shifts out the byte last written into its transmit register. After every address match and every accepted byte it holds the bus clock low until the host sets the release control. This gives software time to serve the single-cycle interrupt pulse.

Top module: `i2c_addr_slave`

## Requirements
- R1: A start is a falling data line while the clock is high, and a stop is a rising data line while the clock is high, both seen after a two-stage synchroniser. A stop returns the block to idle, clears `addressed`, frees the data line and forgets any earlier 10-bit match.
- R2: In 7-bit mode (`addr10_en`=0) the first byte after a start holds the address in bits 7:1 and the direction in bit 0 (1 = master reads). On a match it is acknowledged by holding SDA low during the 9th clock. A non-matching address is not acknowledged, and later bytes are ignored until the next start or stop: no ACK, no interrupt, no change to the receive register.
- R3: An address bit whose `addr_mask` bit is 1 is not compared. All other bits must equal `own_addr`.
- R4: In 10-bit mode the first byte is 11110, then address bits 9:8, then the direction bit. A matching write header is acknowledged without an interrupt or clock hold. A second byte that matches address bits 7:0 is acknowledged and sets `addressed`. A second byte that does not match is not acknowledged.
- R5: In 10-bit mode a header with direction bit 1 is acknowledged only after a full 10-bit match since the last stop. This is normally reached through a repeated start. It then enters read direction and sets `is_read`.
- R6: Each data byte accepted in write direction is presented on `rx_data` with `rx_full`=1. `rx_rd` clears `rx_full`.
- R7: `slv_irq` is a one-cycle pulse on these events: an address match, a byte moved into the receive register, and a transmitted byte acknowledged by the master.
- R8: If a byte completes while `rx_full`=1 and `rx_rd` is low, the byte is not acknowledged and `overrun` is set. `rx_data` keeps the old value and no clock hold follows. `rx_rd` clears `overrun`.
- R9: When `rx_rd` is high in the same cycle as a byte completes into a full receive register, the new byte is accepted, acknowledged and stored, and `overrun` stays 0.
- R10: After the acknowledge clock of an address match, an accepted byte or a master-acknowledged transmit byte, `scl_oe` stays 1 until a `scl_release` pulse. The cycle after that pulse, `scl_oe` is 0.
- R11: In read direction the byte in the transmit register (written with `tx_wr`) is loaded at clock release and sent MSB first. A master NACK ends the transfer with SDA released.
- R12: After reset both line enables are 0, and `rx_full`, `overrun`, `addressed`, `is_read` and `slv_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| scl_oe | output | 1 | 1 pulls the clock line low (stretch) |
| sda_oe | output | 1 | 1 pulls the data line low |
| own_addr | input | 10 | Own address; bits 6:0 used in 7-bit mode |
| addr_mask | input | 10 | 1 marks an address bit as don't-care |
| addr10_en | input | 1 | 1 selects 10-bit addressing |
| tx_wr | input | 1 | Write pulse for the transmit register |
| tx_wdata | input | 8 | Transmit register write data |
| rx_rd | input | 1 | Read pulse for the receive register |
| rx_data | output | 8 | Receive holding register |
| rx_full | output | 1 | Receive holding register holds unread data |
| overrun | output | 1 | A byte arrived while the holding register was full |
| scl_release | input | 1 | Pulse that ends a clock hold |
| addressed | output | 1 | The block matched its address in this transfer |
| is_read | output | 1 | Direction of the matched address (1 = master reads) |
| slv_irq | output | 1 | One-cycle slave event pulse |

## Verification
Two things can land in one clock cycle: the host reading the receive register, and a new byte completing into that still-full register. The bench makes this happen by pulsing `rx_rd` exactly at the eighth rising bus clock. It counts the two synchroniser stages and the edge register to place the pulse. It then expects the byte to be acknowledged and stored with no overrun. The same sequence without the read pulse must give a NACK, keep the old data and raise `overrun`.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 10;
  localparam int CNT_W    = $clog2(BYTE_W + 1);
  localparam logic [4:0] HDR10_TAG = 5'b11110;

  typedef enum logic [2:0] {
    SL_IDLE, SL_ADR1, SL_ADR2, SL_RXD, SL_TXD, SL_SKIP
  } sl_state_t;

  // compare the low nb bits, masked bits are don't-care
  function automatic logic masked_eq(input logic [ADDR_W-1:0] got,
                                     input logic [ADDR_W-1:0] own,
                                     input logic [ADDR_W-1:0] msk,
                                     input int nb);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < ADDR_W; i++)
      if (i < nb && !msk[i] && (got[i] != own[i])) ok = 1'b0;
    return ok;
  endfunction

  // 10-bit header: tag plus address bits 9:8 under mask
  function automatic logic hdr10_hit(input logic [BYTE_W-1:0] b,
                                     input logic [ADDR_W-1:0] own,
                                     input logic [ADDR_W-1:0] msk);
    return (b[7:3] == HDR10_TAG) &&
           masked_eq({8'b0, b[2:1]}, {8'b0, own[9:8]}, {8'b0, msk[9:8]}, 2);
  endfunction
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_p  <= scl_ff[STAGES-1];
      sda_p  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [BYTE_W-1:0] push_data,
  input  logic              rd,
  input  logic              ovr_set,
  input  logic              tx_wr,
  input  logic [BYTE_W-1:0] tx_wdata,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_full,
  output logic              overrun,
  output logic [BYTE_W-1:0] tx_hold
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_full <= 1'b0;
      overrun <= 1'b0;
      tx_hold <= '0;
    end else begin
      if (push) begin
        rx_data <= push_data;
        rx_full <= 1'b1;
      end else if (rd) begin
        rx_full <= 1'b0;
      end
      if (ovr_set)  overrun <= 1'b1;
      else if (rd)  overrun <= 1'b0;
      if (tx_wr)    tx_hold <= tx_wdata;
    end
  end
endmodule

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave
  import i2cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [ADDR_W-1:0] addr_mask,
  input  logic              addr10_en,
  input  logic              tx_wr,
  input  logic [BYTE_W-1:0] tx_wdata,
  input  logic              rx_rd,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_full,
  output logic              overrun,
  input  logic              scl_release,
  output logic              addressed,
  output logic              is_read,
  output logic              slv_irq
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  sl_state_t state, nxt_q, dec_nxt;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sr, txsr, rcv_byte, tx_hold;
  logic in_ack, ack_q, hold_arm, hold_act, rel_bit, mack, sda_oe_q, hdr10_ok, irq_q;
  logic dec_ack, dec_hit, dec_dir, dec_hold, dec_push, dec_ovr, dec_h10;
  logic rcv_st, byte_done, tx_ack_fall, rx_push, ovr_evt, clr_rel, irq_d;

  i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det));

  // named events
  assign rcv_st      = (state == SL_ADR1) || (state == SL_ADR2) || (state == SL_RXD);
  assign rcv_byte    = {sr[BYTE_W-2:0], sda_s};
  assign byte_done   = rcv_st && scl_rise && !in_ack && (cnt == LAST_BIT);
  assign tx_ack_fall = (state == SL_TXD) && scl_fall && in_ack;
  assign rx_push     = byte_done && dec_push;
  assign ovr_evt     = byte_done && dec_ovr;
  assign clr_rel     = (byte_done && dec_hold) || (tx_ack_fall && mack);
  assign irq_d       = (byte_done && (dec_hit || dec_push)) || (tx_ack_fall && mack);

  // decision at byte completion
  always_comb begin
    dec_ack = 1'b0; dec_hit = 1'b0; dec_dir = 1'b0; dec_hold = 1'b0;
    dec_push = 1'b0; dec_ovr = 1'b0; dec_h10 = 1'b0; dec_nxt = SL_SKIP;
    case (state)
      SL_ADR1: begin
        if (!addr10_en) begin
          if (masked_eq({3'b0, rcv_byte[7:1]}, own_addr, addr_mask, 7)) begin
            dec_ack = 1'b1; dec_hit = 1'b1; dec_dir = rcv_byte[0]; dec_hold = 1'b1;
            dec_nxt = rcv_byte[0] ? SL_TXD : SL_RXD;
          end
        end else if (hdr10_hit(rcv_byte, own_addr, addr_mask)) begin
          if (!rcv_byte[0]) begin
            dec_ack = 1'b1; dec_nxt = SL_ADR2;
          end else if (hdr10_ok) begin
            dec_ack = 1'b1; dec_hit = 1'b1; dec_dir = 1'b1; dec_hold = 1'b1;
            dec_nxt = SL_TXD;
          end
        end
      end
      SL_ADR2: begin
        if (masked_eq({2'b0, rcv_byte}, own_addr, addr_mask, 8)) begin
          dec_ack = 1'b1; dec_hit = 1'b1; dec_h10 = 1'b1; dec_hold = 1'b1;
          dec_nxt = SL_RXD;
        end
      end
      SL_RXD: begin
        if (rx_full && !rx_rd) dec_ovr = 1'b1;
        else begin
          dec_push = 1'b1; dec_ack = 1'b1; dec_hold = 1'b1; dec_nxt = SL_RXD;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rel_bit <= 1'b1;
    else if (scl_release) rel_bit <= 1'b1;
    else if (clr_rel) rel_bit <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SL_IDLE; nxt_q <= SL_IDLE; cnt <= '0; sr <= '0; txsr <= '0;
      in_ack <= 1'b0; ack_q <= 1'b0; hold_arm <= 1'b0; hold_act <= 1'b0;
      mack <= 1'b0; sda_oe_q <= 1'b0; addressed <= 1'b0; is_read <= 1'b0;
      hdr10_ok <= 1'b0; irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      if (start_det || stop_det) begin
        state <= stop_det ? SL_IDLE : SL_ADR1;
        cnt <= '0; in_ack <= 1'b0; sda_oe_q <= 1'b0; hold_act <= 1'b0;
        addressed <= 1'b0; is_read <= 1'b0;
        if (stop_det) hdr10_ok <= 1'b0;
      end else begin
        if (hold_act && rel_bit) begin
          hold_act <= 1'b0;
          if (state == SL_TXD) begin
            txsr <= tx_hold; sda_oe_q <= ~tx_hold[BYTE_W-1];
          end
        end
        if (rcv_st) begin
          if (scl_rise && !in_ack && cnt < ALL_BITS) begin
            sr <= rcv_byte; cnt <= cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              ack_q <= dec_ack; nxt_q <= dec_nxt; hold_arm <= dec_hold;
              if (dec_hit) begin addressed <= 1'b1; is_read <= dec_dir; end
              if (dec_h10) hdr10_ok <= 1'b1;
            end
          end
          if (scl_fall && !in_ack && cnt == ALL_BITS) begin
            in_ack <= 1'b1; sda_oe_q <= ack_q;
          end
          if (scl_fall && in_ack) begin
            in_ack <= 1'b0; sda_oe_q <= 1'b0; cnt <= '0;
            state <= nxt_q; hold_act <= hold_arm;
          end
        end else if (state == SL_TXD) begin
          if (scl_rise && !in_ack) cnt <= cnt + 1'b1;
          if (scl_rise && in_ack)  mack <= ~sda_s;
          if (scl_fall && !in_ack && cnt != '0) begin
            if (cnt == ALL_BITS) begin
              in_ack <= 1'b1; sda_oe_q <= 1'b0;
            end else begin
              txsr <= {txsr[BYTE_W-2:0], 1'b0}; sda_oe_q <= ~txsr[BYTE_W-2];
            end
          end
          if (tx_ack_fall) begin
            in_ack <= 1'b0; cnt <= '0;
            if (mack) hold_act <= 1'b1;
            else      state <= SL_SKIP;
          end
        end
      end
    end
  end

  i2cs_regs u_regs (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .push_data(rcv_byte), .rd(rx_rd),
    .ovr_set(ovr_evt), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_data(rx_data),
    .rx_full(rx_full), .overrun(overrun), .tx_hold(tx_hold));

  assign scl_oe  = hold_act && !rel_bit;
  assign sda_oe  = sda_oe_q;
  assign slv_irq = irq_q;
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       slv_irq,
  input logic       stop_det,
  input logic       addressed,
  input logic       sda_oe,
  input logic       scl_release,
  input logic       scl_oe,
  input logic       rx_push,
  input logic       rx_full,
  input logic       overrun,
  input logic [7:0] rx_data
);
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    slv_irq |=> !slv_irq); // R7
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!addressed && !sda_oe)); // R1
  AST_RELEASE_FREES_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    scl_release |=> !scl_oe); // R10
  AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> rx_full); // R6
  AST_OVERRUN_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $stable(rx_data)); // R8
endmodule

bind i2c_addr_slave i2cs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .slv_irq(slv_irq), .stop_det(stop_det),
  .addressed(addressed), .sda_oe(sda_oe), .scl_release(scl_release),
  .scl_oe(scl_oe), .rx_push(rx_push), .rx_full(rx_full), .overrun(overrun),
  .rx_data(rx_data));

// File: tb/i2c_addr_slave_bench.sv
module i2c_addr_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_oe, sda_oe, scl_bus, sda_bus;
  logic [9:0] own_addr = 10'h052, addr_mask = 10'h000;
  logic addr10_en = 1'b0, tx_wr = 1'b0, rx_rd = 1'b0, scl_release = 1'b0;
  logic [7:0] tx_wdata = 8'h00, rx_data;
  logic rx_full, overrun, addressed, is_read, slv_irq;
  int checks = 0, fails = 0, irq_cnt = 0;
  bit irq_prev = 1'b0, done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign scl_bus = ~(m_scl_low | scl_oe);
  assign sda_bus = ~(m_sda_low | sda_oe);

  i2c_addr_slave u_i2c_addr_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .own_addr(own_addr), .addr_mask(addr_mask), .addr10_en(addr10_en),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rx_data(rx_data),
    .rx_full(rx_full), .overrun(overrun), .scl_release(scl_release),
    .addressed(addressed), .is_read(is_read), .slv_irq(slv_irq));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-clock model: interrupt is a lone pulse (R7)
  always @(negedge clk) begin
    if (rst_n) begin
      if (slv_irq) begin
        irq_cnt++;
        chk("R7", "irq width", int'(irq_prev), 0);
      end
      irq_prev = slv_irq;
    end
  end

  task automatic hp(); repeat (HALF) @(negedge clk); endtask
  task automatic scl_up();
    m_scl_low = 1'b0; @(negedge clk);
    while (!scl_bus) @(negedge clk);
  endtask
  task automatic do_start(); m_sda_low = 1'b1; hp(); m_scl_low = 1'b1; hp(); endtask
  task automatic do_rstart();
    repeat (2) @(negedge clk); m_sda_low = 1'b0; hp(); scl_up(); hp();
    m_sda_low = 1'b1; hp(); m_scl_low = 1'b1; hp();
  endtask
  task automatic do_stop();
    repeat (2) @(negedge clk); m_sda_low = 1'b1; hp(); scl_up(); hp();
    m_sda_low = 1'b0; hp();
  endtask
  task automatic release_scl();
    @(negedge clk); scl_release = 1'b1; @(negedge clk); scl_release = 1'b0;
    repeat (2) @(negedge clk);
  endtask
  task automatic host_read(); @(negedge clk); rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0; endtask
  task automatic host_tx(input logic [7:0] d);
    @(negedge clk); tx_wr = 1'b1; tx_wdata = d; @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] b, input bit rd_last, output bit ack, output bit held);
    for (int i = 7; i >= 0; i--) begin
      repeat (2) @(negedge clk); m_sda_low = ~b[i]; hp();
      m_scl_low = 1'b0;
      if (i == 0 && rd_last) begin
        repeat (2) @(negedge clk); rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
      end
      while (!scl_bus) @(negedge clk);
      hp(); m_scl_low = 1'b1;
    end
    repeat (2) @(negedge clk); m_sda_low = 1'b0; hp();
    scl_up(); repeat (HALF/2) @(negedge clk); ack = !sda_bus;
    repeat (HALF/2) @(negedge clk); m_scl_low = 1'b1;
    repeat (6) @(negedge clk); held = scl_oe;
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] b, output bit held);
    for (int i = 7; i >= 0; i--) begin
      hp(); scl_up(); repeat (HALF/2) @(negedge clk); b[i] = sda_bus;
      repeat (HALF/2) @(negedge clk); m_scl_low = 1'b1;
    end
    repeat (2) @(negedge clk); m_sda_low = give_ack; hp(); scl_up(); hp();
    m_scl_low = 1'b1; repeat (2) @(negedge clk); m_sda_low = 1'b0;
    repeat (6) @(negedge clk); held = scl_oe;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ack, held;
    logic [7:0] rb;
    int c0;
    repeat (4) @(negedge clk); rst_n = 1'b1; @(negedge clk);
    // R12 reset state
    chk("R12", "scl_oe", scl_oe, 0);   chk("R12", "sda_oe", sda_oe, 0);
    chk("R12", "rx_full", rx_full, 0); chk("R12", "overrun", overrun, 0);
    chk("R12", "addressed", addressed, 0); chk("R12", "is_read", is_read, 0);
    chk("R12", "irq", slv_irq, 0);

    // 7-bit write, then overrun
    c0 = irq_cnt;
    do_start(); wr_byte(8'hA4, 0, ack, held);
    chk("R2", "addr ack", ack, 1); chk("R10", "hold after addr", held, 1);
    chk("R2", "addressed", addressed, 1); chk("R2", "is_read", is_read, 0);
    chk("R7", "irq on match", irq_cnt - c0, 1);
    release_scl(); chk("R10", "free after release", scl_oe, 0);
    wr_byte(8'h3C, 0, ack, held);
    chk("R6", "data ack", ack, 1); chk("R6", "rx_full", rx_full, 1);
    chk("R6", "rx_data", rx_data, 8'h3C); chk("R7", "irq on byte", irq_cnt - c0, 2);
    chk("R10", "hold after byte", held, 1);
    release_scl();
    wr_byte(8'h99, 0, ack, held);
    chk("R8", "overrun nack", ack, 0); chk("R8", "overrun flag", overrun, 1);
    chk("R8", "old data kept", rx_data, 8'h3C); chk("R8", "no hold", held, 0);
    chk("R8", "no irq", irq_cnt - c0, 2);
    do_stop(); chk("R1", "stop clears addressed", addressed, 0);
    host_read(); chk("R8", "rd clears overrun", overrun, 0); chk("R6", "rd clears full", rx_full, 0);

    // non-matching address, following byte ignored
    c0 = irq_cnt;
    do_start(); wr_byte(8'hC4, 0, ack, held);
    chk("R2", "mismatch nack", ack, 0); chk("R2", "mismatch no hold", held, 0);
    wr_byte(8'h77, 0, ack, held);
    chk("R2", "ignored byte nack", ack, 0); chk("R2", "ignored rx_full", rx_full, 0);
    chk("R2", "ignored addressed", addressed, 0); chk("R2", "ignored irq", irq_cnt - c0, 0);
    do_stop();

    // mask
    addr_mask = 10'h003;
    do_start(); wr_byte(8'hA2, 0, ack, held); chk("R3", "masked match", ack, 1);
    release_scl(); do_stop();
    addr_mask = 10'h000;
    do_start(); wr_byte(8'hA2, 0, ack, held); chk("R3", "unmasked mismatch", ack, 0);
    do_stop();

    // read coinciding with byte completion
    do_start(); wr_byte(8'hA4, 0, ack, held); release_scl();
    wr_byte(8'h11, 0, ack, held); release_scl();
    wr_byte(8'h22, 1, ack, held);
    chk("R9", "same-cycle ack", ack, 1); chk("R9", "no overrun", overrun, 0);
    chk("R9", "new data", rx_data, 8'h22); chk("R9", "still full", rx_full, 1);
    release_scl(); do_stop(); host_read();

    // 7-bit read
    host_tx(8'hC3);
    c0 = irq_cnt;
    do_start(); wr_byte(8'hA5, 0, ack, held);
    chk("R11", "read addr ack", ack, 1); chk("R11", "is_read", is_read, 1);
    release_scl(); rd_byte(1, rb, held);
    chk("R11", "tx byte 1", rb, 8'hC3); chk("R10", "hold after tx ack", held, 1);
    chk("R7", "irq on tx ack", irq_cnt - c0, 2);
    host_tx(8'h5A); release_scl(); rd_byte(0, rb, held);
    chk("R11", "tx byte 2", rb, 8'h5A); chk("R11", "sda freed after nack", sda_oe, 0);
    chk("R11", "no hold after nack", held, 0);
    do_stop();

    // 10-bit write then read via repeated start
    addr10_en = 1'b1; own_addr = 10'h2B5;
    c0 = irq_cnt;
    do_start(); wr_byte(8'hF4, 0, ack, held);
    chk("R4", "header ack", ack, 1); chk("R4", "header no hold", held, 0);
    chk("R4", "header no irq", irq_cnt - c0, 0); chk("R4", "header not addressed", addressed, 0);
    wr_byte(8'hB5, 0, ack, held);
    chk("R4", "low byte ack", ack, 1); chk("R4", "addressed", addressed, 1);
    chk("R4", "irq", irq_cnt - c0, 1);
    host_tx(8'h6E); release_scl();
    do_rstart(); wr_byte(8'hF5, 0, ack, held);
    chk("R5", "read header ack", ack, 1); chk("R5", "is_read", is_read, 1);
    release_scl(); rd_byte(0, rb, held); chk("R5", "10-bit tx", rb, 8'h6E);
    do_stop();
    do_start(); wr_byte(8'hF5, 0, ack, held); chk("R5", "read header w/o match", ack, 0);
    do_stop();
    do_start(); wr_byte(8'hF4, 0, ack, held);
    wr_byte(8'hB4, 0, ack, held); chk("R4", "low byte mismatch", ack, 0);
    do_stop();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule